// File: doc/BRIEF.md
# Core control and status register bank

This block is the control/status register bank of a small 32-bit RISC core. It keeps a three-bit interrupt-enable word, the exception vector base, the debug vector base, a debug control word, a free-running cycle counter, a read-only configuration word, and a parameterised set of instruction breakpoint and data watchpoint address slots. The core reaches it through one combinational read port and one write port. Each port is indexed by a 5-bit register number that the core takes from instruction bits 25:21.

The bank also handles the interrupt-enable side effects of taking and leaving exceptions and debug breaks. On entry the live enable bit is parked in a saved copy and cleared. On return the live bit is restored from the matching saved copy. Every access is checked per register and per direction, and an illegal one raises a flag in the same cycle. The interrupt mask and pending registers, the host data channel and the cache-control registers live elsewhere. Their numbers are decoded here only so that they read as zero or swallow writes.

Top module: `csr_bank_top`

## Requirements
- R1: After reset, the enable word, both base registers, the debug control word, all breakpoint and watchpoint slots and the cycle counter are zero.
- R2: Register 0 is the enable word: bit 0 is the live enable, bit 1 the copy saved for exceptions, bit 2 the copy saved for breaks. A write to it is visible on read and on `irq_enable` from the next cycle on. `pipe_resync` is high for exactly that one cycle.
- R3: Exception entry copies the live bit into bit 1 and clears the live bit. Exception return sets the live bit to the value of bit 1.
- R4: Break entry copies the live bit into bit 2 and clears the live bit. Break return sets the live bit to the value of bit 2.
- R5: When several updates to the enable word arrive in the same cycle, only the one of highest priority applies. The order is: exception entry, then break entry, then exception return, then break return, then a register write.
- R6: Register 5 reads the cycle counter, which advances by one every clock after reset. Register 6 reads the configuration word {CONF_TAG[23:0], N_WTCH[3:0], N_BKPT[3:0]}. A write to either raises `csr_wr_illegal` and changes nothing.
- R7: Registers 7 (exception base) and 9 (debug base) always read with bits 7:0 zero, whatever was written. Register 8 (debug control) keeps all 32 written bits.
- R8: Registers 3, 4, 16-19 and 24-27 are write-only. Reading one returns zero and raises `csr_rd_illegal`.
- R9: Registers 16+n are breakpoint slots and 24+n are watchpoint slots, each shown on its output lane n. A write to a slot at or above its configured count raises `csr_wr_illegal` and leaves every lane unchanged.
- R10: Registers 1, 2, 10 and 11 read zero and accept writes without a flag. The write has no visible effect.
- R11: Registers 12-15, 20-23 and 28-31 are unknown. A read returns zero with `csr_rd_illegal`. A write raises `csr_wr_illegal` and changes nothing.
- R12: With `csr_rd_en` low, `csr_rd_data` is zero and `csr_rd_illegal` is low. With `csr_wr_en` low, nothing is written and `csr_wr_illegal` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_rd_en | input | 1 | Read request |
| csr_rd_num | input | 5 | Register number to read |
| csr_rd_data | output | 32 | Read data (combinational) |
| csr_rd_illegal | output | 1 | Read access is not allowed |
| csr_wr_en | input | 1 | Write request |
| csr_wr_num | input | 5 | Register number to write |
| csr_wr_data | input | 32 | Write data |
| csr_wr_illegal | output | 1 | Write access is not allowed |
| exc_enter | input | 1 | Exception taken this cycle |
| brk_enter | input | 1 | Debug break taken this cycle |
| exc_return | input | 1 | Return from exception this cycle |
| brk_return | input | 1 | Return from break this cycle |
| irq_enable | output | 1 | Live interrupt enable |
| pipe_resync | output | 1 | One-cycle request to refetch after an enable write |
| exc_base | output | 32 | Exception vector base |
| dbg_base | output | 32 | Debug vector base |
| dbg_ctrl | output | 32 | Debug control word |
| bkpt_addr | output | 128 | Breakpoint slots, lane n at bits 32n+31:32n |
| wtch_addr | output | 128 | Watchpoint slots, lane n at bits 32n+31:32n |

## Verification
The assertions check the following on every cycle:
- the enable-word transitions on entry and return, including the saved copy taken from the previous live bit;
- the resync pulse after every enable write;
- the steady advance of the cycle counter;
- the flags on writes to read-only registers and on reads of unknown registers;
- that an out-of-range breakpoint write leaves the breakpoint lanes stable;
- that the read port is silent when not enabled.

Three things only the bench scenarios can show:
- the full priority order among simultaneous events and writes;
- the low-bit masking of the base registers;
- that writes to the ignored numbers leave every output unchanged.

The bench shows these by running sweeps over all 32 register numbers against its behavioural model.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

    localparam int XLEN      = 32;
    localparam int NUM_W     = 5;
    localparam int SLOT_MAX  = 4;
    localparam int SLOT_IDX_W = $clog2(SLOT_MAX);
    localparam int BASE_ZERO_BITS = 8;

    localparam logic [NUM_W-1:0] CSR_IEN      = 5'd0;
    localparam logic [NUM_W-1:0] CSR_IMASK    = 5'd1;
    localparam logic [NUM_W-1:0] CSR_IPEND    = 5'd2;
    localparam logic [NUM_W-1:0] CSR_ICTL     = 5'd3;
    localparam logic [NUM_W-1:0] CSR_DCTL     = 5'd4;
    localparam logic [NUM_W-1:0] CSR_CYCLE    = 5'd5;
    localparam logic [NUM_W-1:0] CSR_CONFIG   = 5'd6;
    localparam logic [NUM_W-1:0] CSR_EXC_BASE = 5'd7;
    localparam logic [NUM_W-1:0] CSR_DBG_CTRL = 5'd8;
    localparam logic [NUM_W-1:0] CSR_DBG_BASE = 5'd9;
    localparam logic [NUM_W-1:0] CSR_HOST_TX  = 5'd10;
    localparam logic [NUM_W-1:0] CSR_HOST_RX  = 5'd11;

    // enable word: bit 2 break copy, bit 1 exception copy, bit 0 live
    typedef struct packed {
        logic brk;
        logic exc;
        logic live;
    } ien_t;

    typedef enum logic [2:0] {
        IEV_HOLD,
        IEV_EXC_IN,
        IEV_BRK_IN,
        IEV_EXC_OUT,
        IEV_BRK_OUT,
        IEV_LOAD
    } ien_ev_e;

    // slot groups: 16..19 breakpoints, 24..27 watchpoints
    function automatic logic is_slot(input logic [NUM_W-1:0] n);
        return n[4] && !n[2];
    endfunction

    function automatic logic is_wtch(input logic [NUM_W-1:0] n);
        return is_slot(n) && n[3];
    endfunction

    function automatic logic csr_readable(input logic [NUM_W-1:0] n);
        logic ok;
        case (n)
            CSR_IEN, CSR_IMASK, CSR_IPEND, CSR_CYCLE, CSR_CONFIG,
            CSR_EXC_BASE, CSR_DBG_CTRL, CSR_DBG_BASE,
            CSR_HOST_TX, CSR_HOST_RX: ok = 1'b1;
            default:                  ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic csr_writable(input logic [NUM_W-1:0] n);
        logic ok;
        case (n)
            CSR_IEN, CSR_IMASK, CSR_IPEND, CSR_ICTL, CSR_DCTL,
            CSR_EXC_BASE, CSR_DBG_CTRL, CSR_DBG_BASE,
            CSR_HOST_TX, CSR_HOST_RX: ok = 1'b1;
            default:                  ok = is_slot(n);
        endcase
        return ok;
    endfunction

    function automatic logic [XLEN-1:0] align_base(input logic [XLEN-1:0] v);
        return v & ~((XLEN'(1) << BASE_ZERO_BITS) - XLEN'(1));
    endfunction

    function automatic ien_ev_e pick_event(input logic exc_in, input logic brk_in,
                                           input logic exc_out, input logic brk_out,
                                           input logic load);
        if (exc_in)       return IEV_EXC_IN;
        else if (brk_in)  return IEV_BRK_IN;
        else if (exc_out) return IEV_EXC_OUT;
        else if (brk_out) return IEV_BRK_OUT;
        else if (load)    return IEV_LOAD;
        return IEV_HOLD;
    endfunction

endpackage

// File: rtl/csr_access_check.sv
module csr_access_check
    import csr_bank_pkg::*;
#(
    parameter int N_BKPT = 2,
    parameter int N_WTCH = 3
) (
    input  logic             rd_en,
    input  logic [NUM_W-1:0] rd_num,
    input  logic             wr_en,
    input  logic [NUM_W-1:0] wr_num,
    output logic             rd_bad,
    output logic             wr_bad,
    output logic             wr_ok
);
    logic [31:0] slot_limit;
    logic        slot_in_range;

    always_comb begin
        slot_limit    = is_wtch(wr_num) ? 32'(N_WTCH) : 32'(N_BKPT);
        slot_in_range = {30'd0, wr_num[1:0]} < slot_limit;
        rd_bad = rd_en && !csr_readable(rd_num);
        wr_bad = wr_en && (!csr_writable(wr_num) || (is_slot(wr_num) && !slot_in_range));
        wr_ok  = wr_en && !wr_bad;
    end
endmodule

// File: rtl/csr_ien_unit.sv
module csr_ien_unit
    import csr_bank_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic exc_in,
    input  logic brk_in,
    input  logic exc_out,
    input  logic brk_out,
    input  logic load,
    input  ien_t load_val,
    output ien_t ien_q,
    output logic resync_q
);
    ien_ev_e ev;

    always_comb ev = pick_event(exc_in, brk_in, exc_out, brk_out, load);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q    <= '0;
            resync_q <= 1'b0;
        end else begin
            resync_q <= load;
            case (ev)
                IEV_EXC_IN: begin
                    ien_q.exc  <= ien_q.live;
                    ien_q.live <= 1'b0;
                end
                IEV_BRK_IN: begin
                    ien_q.brk  <= ien_q.live;
                    ien_q.live <= 1'b0;
                end
                IEV_EXC_OUT: ien_q.live <= ien_q.exc;
                IEV_BRK_OUT: ien_q.live <= ien_q.brk;
                IEV_LOAD:    ien_q      <= load_val;
                default:     ien_q      <= ien_q;
            endcase
        end
    end
endmodule

// File: rtl/csr_dbg_slots.sv
module csr_dbg_slots
    import csr_bank_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_stb,
    input  logic [SLOT_IDX_W-1:0]    wr_idx,
    input  logic [XLEN-1:0]          wr_data,
    output logic [SLOT_MAX*XLEN-1:0] slots_flat
);
    for (genvar i = 0; i < SLOT_MAX; i++) begin : g_slot
        if (i < NUM_SLOTS) begin : g_live
            logic [XLEN-1:0] r;
            always_ff @(posedge clk) begin
                if (rst)
                    r <= '0;
                else if (wr_stb && wr_idx == SLOT_IDX_W'(i))
                    r <= wr_data;
            end
            assign slots_flat[i*XLEN +: XLEN] = r;
        end else begin : g_absent
            assign slots_flat[i*XLEN +: XLEN] = '0;
        end
    end
endmodule

// File: rtl/csr_bank_top.sv
module csr_bank_top
    import csr_bank_pkg::*;
#(
    parameter int          N_BKPT   = 2,
    parameter int          N_WTCH   = 3,
    parameter logic [23:0] CONF_TAG = 24'h5C0A11
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     csr_rd_en,
    input  logic [4:0]               csr_rd_num,
    output logic [31:0]              csr_rd_data,
    output logic                     csr_rd_illegal,
    input  logic                     csr_wr_en,
    input  logic [4:0]               csr_wr_num,
    input  logic [31:0]              csr_wr_data,
    output logic                     csr_wr_illegal,
    input  logic                     exc_enter,
    input  logic                     brk_enter,
    input  logic                     exc_return,
    input  logic                     brk_return,
    output logic                     irq_enable,
    output logic                     pipe_resync,
    output logic [31:0]              exc_base,
    output logic [31:0]              dbg_base,
    output logic [31:0]              dbg_ctrl,
    output logic [127:0]             bkpt_addr,
    output logic [127:0]             wtch_addr
);
    localparam logic [XLEN-1:0] CONF_WORD = {CONF_TAG, 4'(N_WTCH), 4'(N_BKPT)};

    logic            wr_ok;
    logic            ien_load;
    ien_t            ien_q;
    logic [XLEN-1:0] cyc_q;
    logic [XLEN-1:0] exc_base_q, dbg_base_q, dbg_ctrl_q;
    logic            bk_stb, wc_stb;

    csr_access_check #(.N_BKPT(N_BKPT), .N_WTCH(N_WTCH)) u_check (
        .rd_en  (csr_rd_en),
        .rd_num (csr_rd_num),
        .wr_en  (csr_wr_en),
        .wr_num (csr_wr_num),
        .rd_bad (csr_rd_illegal),
        .wr_bad (csr_wr_illegal),
        .wr_ok  (wr_ok)
    );

    assign ien_load = wr_ok && csr_wr_num == CSR_IEN;

    csr_ien_unit u_ien (
        .clk      (clk),
        .rst      (rst),
        .exc_in   (exc_enter),
        .brk_in   (brk_enter),
        .exc_out  (exc_return),
        .brk_out  (brk_return),
        .load     (ien_load),
        .load_val (ien_t'(csr_wr_data[2:0])),
        .ien_q    (ien_q),
        .resync_q (pipe_resync)
    );

    assign bk_stb = wr_ok && is_slot(csr_wr_num) && !is_wtch(csr_wr_num);
    assign wc_stb = wr_ok && is_wtch(csr_wr_num);

    csr_dbg_slots #(.NUM_SLOTS(N_BKPT)) u_bkpt (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (bk_stb),
        .wr_idx     (csr_wr_num[1:0]),
        .wr_data    (csr_wr_data),
        .slots_flat (bkpt_addr)
    );

    csr_dbg_slots #(.NUM_SLOTS(N_WTCH)) u_wtch (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (wc_stb),
        .wr_idx     (csr_wr_num[1:0]),
        .wr_data    (csr_wr_data),
        .slots_flat (wtch_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) cyc_q <= '0;
        else     cyc_q <= cyc_q + XLEN'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_base_q <= '0;
            dbg_base_q <= '0;
            dbg_ctrl_q <= '0;
        end else if (wr_ok) begin
            case (csr_wr_num)
                CSR_EXC_BASE: exc_base_q <= align_base(csr_wr_data);
                CSR_DBG_BASE: dbg_base_q <= align_base(csr_wr_data);
                CSR_DBG_CTRL: dbg_ctrl_q <= csr_wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        csr_rd_data = '0;
        if (csr_rd_en) begin
            case (csr_rd_num)
                CSR_IEN:      csr_rd_data = {29'd0, ien_q};
                CSR_CYCLE:    csr_rd_data = cyc_q;
                CSR_CONFIG:   csr_rd_data = CONF_WORD;
                CSR_EXC_BASE: csr_rd_data = exc_base_q;
                CSR_DBG_CTRL: csr_rd_data = dbg_ctrl_q;
                CSR_DBG_BASE: csr_rd_data = dbg_base_q;
                default:      csr_rd_data = '0;
            endcase
        end
    end

    assign irq_enable = ien_q.live;
    assign exc_base   = exc_base_q;
    assign dbg_base   = dbg_base_q;
    assign dbg_ctrl   = dbg_ctrl_q;
endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk #(
    parameter int N_BKPT = 2
) (
    input logic         clk,
    input logic         rst,
    input logic         rd_en,
    input logic [4:0]   rd_num,
    input logic [31:0]  rd_data,
    input logic         rd_illegal,
    input logic         wr_en,
    input logic [4:0]   wr_num,
    input logic         wr_illegal,
    input logic         exc_enter,
    input logic         brk_enter,
    input logic         exc_return,
    input logic         brk_return,
    input logic         irq_enable,
    input logic         pipe_resync,
    input logic [2:0]   ien,
    input logic [31:0]  cyc,
    input logic [127:0] bkpt_addr
);
    // R2: an enable write is followed by one resync pulse
    a_r2_resync_after_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_num == 5'd0) |=> pipe_resync);

    // R3: exception entry parks the live bit and clears it
    a_r3_exc_entry: assert property (@(posedge clk) disable iff (rst)
        exc_enter |=> (!irq_enable && ien[1] == $past(irq_enable)));

    // R4: break entry parks the live bit into the break copy
    a_r4_brk_entry: assert property (@(posedge clk) disable iff (rst)
        (brk_enter && !exc_enter) |=> (!irq_enable && ien[2] == $past(irq_enable)));

    // R4: break return restores from the break copy
    a_r4_brk_return: assert property (@(posedge clk) disable iff (rst)
        (brk_return && !exc_enter && !brk_enter && !exc_return) |=> irq_enable == $past(ien[2]));

    // R6: cycle counter advances every clock
    a_r6_cycle_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cyc == $past(cyc) + 32'd1);

    // R6: writes to the read-only registers are flagged
    a_r6_ro_write_flag: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_num == 5'd5 || wr_num == 5'd6)) |-> wr_illegal);

    // R11: unknown numbers read zero and flag
    a_r11_unknown_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (wr_num == wr_num) && (rd_num[3:2] == 2'b11 || (rd_num[4] && rd_num[2])))
            |-> (rd_illegal && rd_data == 32'd0));

    // R9: an out-of-range breakpoint write leaves all lanes stable
    a_r9_bad_slot_stable: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_num[4:3] == 2'b10 && !wr_num[2] && ({30'd0, wr_num[1:0]} >= 32'(N_BKPT)))
            |=> $stable(bkpt_addr));

    // R12: idle read port is silent
    a_r12_idle_read: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == 32'd0 && !rd_illegal));
endmodule

bind csr_bank_top csr_bank_chk #(.N_BKPT(N_BKPT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (csr_rd_en),
    .rd_num      (csr_rd_num),
    .rd_data     (csr_rd_data),
    .rd_illegal  (csr_rd_illegal),
    .wr_en       (csr_wr_en),
    .wr_num      (csr_wr_num),
    .wr_illegal  (csr_wr_illegal),
    .exc_enter   (exc_enter),
    .brk_enter   (brk_enter),
    .exc_return  (exc_return),
    .brk_return  (brk_return),
    .irq_enable  (irq_enable),
    .pipe_resync (pipe_resync),
    .ien         (ien_q),
    .cyc         (cyc_q),
    .bkpt_addr   (bkpt_addr)
);

// File: tb/sim_csr_bank_top.sv
`timescale 1ns/1ps
module sim_csr_bank_top;
    localparam int          NB  = 2;
    localparam int          NW  = 3;
    localparam logic [23:0] TAG = 24'h5C0A11;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst;
    logic         rd_en, wr_en;
    logic [4:0]   rd_num, wr_num;
    logic [31:0]  wr_data;
    logic         exc_enter, brk_enter, exc_return, brk_return;
    logic [31:0]  rd_data, exc_base, dbg_base, dbg_ctrl;
    logic         rd_illegal, wr_illegal, irq_enable, pipe_resync;
    logic [127:0] bkpt_addr, wtch_addr;

    csr_bank_top #(.N_BKPT(NB), .N_WTCH(NW), .CONF_TAG(TAG)) u0 (
        .clk(clk), .rst(rst),
        .csr_rd_en(rd_en), .csr_rd_num(rd_num), .csr_rd_data(rd_data),
        .csr_rd_illegal(rd_illegal),
        .csr_wr_en(wr_en), .csr_wr_num(wr_num), .csr_wr_data(wr_data),
        .csr_wr_illegal(wr_illegal),
        .exc_enter(exc_enter), .brk_enter(brk_enter),
        .exc_return(exc_return), .brk_return(brk_return),
        .irq_enable(irq_enable), .pipe_resync(pipe_resync),
        .exc_base(exc_base), .dbg_base(dbg_base), .dbg_ctrl(dbg_ctrl),
        .bkpt_addr(bkpt_addr), .wtch_addr(wtch_addr)
    );

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // behavioural reference state
    logic [2:0]  m_ien;
    logic [31:0] m_cyc, m_excb, m_dbgb, m_dctl;
    logic [31:0] m_bk [4];
    logic [31:0] m_wc [4];
    logic        m_resync;
    bit          m_acc;

    function automatic bit rd_legal(input int n);
        return (n <= 2) || (n >= 5 && n <= 11);
    endfunction

    function automatic bit wr_legal(input int n);
        if (n >= 16 && n <= 19) return (n - 16) < NB;
        if (n >= 24 && n <= 27) return (n - 24) < NW;
        return (n <= 4) || (n >= 7 && n <= 11);
    endfunction

    function automatic logic [31:0] exp_read(input int n);
        case (n)
            0: return {29'd0, m_ien};
            5: return m_cyc;
            6: return {TAG, 4'(NW), 4'(NB)};
            7: return m_excb;
            8: return m_dctl;
            9: return m_dbgb;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(input int n);
        if (n == 0) return "R2";
        if (n == 5 || n == 6) return "R6";
        if (n >= 7 && n <= 9) return "R7";
        if (n == 3 || n == 4 || (n >= 16 && n <= 19) || (n >= 24 && n <= 27)) return "R8";
        if (n == 1 || n == 2 || n == 10 || n == 11) return "R10";
        return "R11";
    endfunction

    function automatic string wr_tag(input int n);
        if (n == 5 || n == 6) return "R6";
        if ((n >= 16 && n <= 19) || (n >= 24 && n <= 27)) return "R9";
        if (wr_legal(n)) return "R10";
        return "R11";
    endfunction

    task automatic cmp(input logic [127:0] act, input logic [127:0] exp,
                       input string tag, input string what);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_ien = '0; m_cyc = '0; m_excb = '0; m_dbgb = '0; m_dctl = '0;
            m_resync = 1'b0;
            for (int i = 0; i < 4; i++) begin m_bk[i] = '0; m_wc[i] = '0; end
        end else begin
            m_acc = wr_en && wr_legal(int'(wr_num));
            m_cyc = m_cyc + 32'd1;
            m_resync = m_acc && wr_num == 5'd0;
            if (exc_enter) begin m_ien[1] = m_ien[0]; m_ien[0] = 1'b0; end
            else if (brk_enter) begin m_ien[2] = m_ien[0]; m_ien[0] = 1'b0; end
            else if (exc_return) m_ien[0] = m_ien[1];
            else if (brk_return) m_ien[0] = m_ien[2];
            else if (m_resync) m_ien = wr_data[2:0];
            if (m_acc) begin
                if (wr_num == 5'd7) m_excb = {wr_data[31:8], 8'h00};
                if (wr_num == 5'd9) m_dbgb = {wr_data[31:8], 8'h00};
                if (wr_num == 5'd8) m_dctl = wr_data;
                if (wr_num >= 5'd16 && wr_num <= 5'd19) m_bk[int'(wr_num) - 16] = wr_data;
                if (wr_num >= 5'd24 && wr_num <= 5'd27) m_wc[int'(wr_num) - 24] = wr_data;
            end
        end
    end

    // compare every output against the model on each falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rd_en) begin
                cmp(128'(rd_data), 128'(exp_read(int'(rd_num)) & {32{rd_legal(int'(rd_num))}}),
                    rd_tag(int'(rd_num)), "read data");
                cmp(128'(rd_illegal), 128'(!rd_legal(int'(rd_num))), rd_tag(int'(rd_num)), "read flag");
            end else begin
                cmp(128'(rd_data), 128'(0), "R12", "idle read data");
                cmp(128'(rd_illegal), 128'(0), "R12", "idle read flag");
            end
            if (wr_en)
                cmp(128'(wr_illegal), 128'(!wr_legal(int'(wr_num))), wr_tag(int'(wr_num)), "write flag");
            else
                cmp(128'(wr_illegal), 128'(0), "R12", "idle write flag");
            cmp(128'(irq_enable), 128'(m_ien[0]), "R3", "live enable");
            cmp(128'(pipe_resync), 128'(m_resync), "R2", "resync");
            cmp(128'(exc_base), 128'(m_excb), "R7", "exception base");
            cmp(128'(dbg_base), 128'(m_dbgb), "R7", "debug base");
            cmp(128'(dbg_ctrl), 128'(m_dctl), "R7", "debug control");
            cmp(bkpt_addr, {m_bk[3], m_bk[2], m_bk[1], m_bk[0]}, "R9", "breakpoint lanes");
            cmp(wtch_addr, {m_wc[3], m_wc[2], m_wc[1], m_wc[0]}, "R9", "watchpoint lanes");
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        rd_en = 0; wr_en = 0; exc_enter = 0; brk_enter = 0;
        exc_return = 0; brk_return = 0;
    endtask

    task automatic wr(input int n, input logic [31:0] d);
        wr_en = 1; wr_num = 5'(n); wr_data = d;
        tick();
    endtask

    task automatic look(input int n, input logic [31:0] exp, input string tag);
        rd_en = 1; rd_num = 5'(n);
        @(negedge clk);
        cmp(128'(rd_data), 128'(exp), tag, "scenario read");
        tick();
    endtask

    initial begin
        rst = 1; rd_en = 0; wr_en = 0; rd_num = 0; wr_num = 0; wr_data = 0;
        exc_enter = 0; brk_enter = 0; exc_return = 0; brk_return = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state, seen before any clock after release
        rd_en = 1; rd_num = 5'd5;
        @(negedge clk);
        cmp(128'(rd_data), 128'(0), "R1", "cycle counter");
        cmp(128'(exc_base | dbg_base | dbg_ctrl), 128'(0), "R1", "bases");
        cmp(bkpt_addr | wtch_addr, 128'(0), "R1", "slots");
        cmp(128'(irq_enable), 128'(0), "R1", "live enable");
        tick();
        look(0, 32'h0, "R1");

        // R2 enable write and resync
        wr(0, 32'h1);
        rd_en = 1; rd_num = 5'd0;
        @(negedge clk);
        cmp(128'(pipe_resync), 128'(1), "R2", "resync pulse");
        cmp(128'(rd_data), 128'(1), "R2", "enable readback");
        tick();
        cmp(128'(pipe_resync), 128'(0), "R2", "resync single cycle");

        // R3 / R4 entry and return
        exc_enter = 1; tick(); look(0, 32'h2, "R3");
        exc_return = 1; tick(); look(0, 32'h3, "R3");
        brk_enter = 1; tick(); look(0, 32'h6, "R4");
        brk_return = 1; tick(); look(0, 32'h7, "R4");

        // R5 priority
        exc_enter = 1; brk_enter = 1; wr_en = 1; wr_num = 0; wr_data = 0; tick();
        look(0, 32'h6, "R5");
        exc_return = 1; brk_return = 1; wr_en = 1; wr_num = 0; wr_data = 0; tick();
        look(0, 32'h7, "R5");
        brk_enter = 1; exc_return = 1; tick();
        look(0, 32'h6, "R5");
        wr(0, 32'h0);
        look(0, 32'h0, "R2");

        // R6 read-only registers
        wr_en = 1; wr_num = 5'd6; wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        cmp(128'(wr_illegal), 128'(1), "R6", "config write flag");
        tick();
        wr(5, 32'h0);
        look(6, {TAG, 4'(NW), 4'(NB)}, "R6");

        // R7 base alignment and debug control
        wr(7, 32'hDEAD_BEEF); look(7, 32'hDEAD_BE00, "R7");
        wr(9, 32'h1234_56FF); look(9, 32'h1234_5600, "R7");
        wr(8, 32'hFFFF_0001); look(8, 32'hFFFF_0001, "R7");

        // R9 slots, including absent ones
        for (int i = 0; i < 4; i++) wr(16 + i, 32'h1000_0000 + 32'(i));
        for (int i = 0; i < 4; i++) wr(24 + i, 32'h2000_0000 + 32'(i));
        cmp(bkpt_addr, {64'd0, 32'h1000_0001, 32'h1000_0000}, "R9", "breakpoint set");
        cmp(wtch_addr, {32'd0, 32'h2000_0002, 32'h2000_0001, 32'h2000_0000}, "R9", "watchpoint set");

        // R8 write-only reads
        look(3, 0, "R8"); look(4, 0, "R8");
        for (int i = 16; i < 20; i++) look(i, 0, "R8");
        for (int i = 24; i < 28; i++) look(i, 0, "R8");

        // R10 ignored registers
        for (int i = 0; i < 4; i++) begin
            int n;
            n = (i < 2) ? i + 1 : i + 8;
            wr(n, 32'hFFFF_FFFF);
            look(n, 0, "R10");
        end

        // R11 unknown numbers
        for (int n = 12; n < 32; n++) begin
            if ((n >= 12 && n <= 15) || (n >= 20 && n <= 23) || n >= 28) begin
                wr(n, 32'hCAFE_F00D);
                look(n, 0, "R11");
            end
        end

        // R12 disabled ports
        wr_en = 0; wr_num = 5'd7; wr_data = 32'h5555_5555;
        rd_en = 0; rd_num = 5'd5;
        tick();
        cmp(128'(exc_base), 128'(32'hDEAD_BE00), "R12", "disabled write");

        // sweep of all numbers with mixed events
        for (int n = 0; n < 32; n++) begin
            wr_en = 1; wr_num = 5'(n); wr_data = 32'h0101_0101 * 32'(n) ^ 32'hA5A5_5A5A;
            rd_en = 1; rd_num = 5'(31 - n);
            exc_enter = (n % 7 == 3); brk_return = (n % 5 == 1);
            tick();
        end
        for (int n = 0; n < 32; n++) look(n, exp_read(n) & {32{rd_legal(n)}}, rd_tag(n));

        tick();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog R1..: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule